// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Byte Readout

This block takes a two-wire serial avionics word stream that an external line receiver has already turned into two digital lines. A pulse on `lineOne` carries a logical one and a pulse on `lineZero` carries a logical zero. The rising edge of either line acts as the bit clock. Each recovered bit is shifted into a 32-bit input register. A separate, slower gap clock times the quiet interval between words. Once enough gap-clock periods pass with no bit pulse, the word is closed. Its bit count is checked, and it can also be checked for odd parity. The word is then copied into a receive buffer and the input register is cleared for the next word.

A host sees a ready flag and an error flag. It fetches the buffered word as four 8-bit bytes, one byte per pulse on the read strobe, starting with the least significant byte. The first strobe of a word drops the ready flag. The data bus is driven only while the strobe is high, and an output-enable follows the strobe for use with a tristate bus.

Top module: `arinc_word_rx`

## Requirements
- R1: A rising edge on `lineOne` receives a 1 and a rising edge on `lineZero` receives a 0. The first bit of a word lands at bit 1 (index 0) of a correctly sized word.
- R2: A word ends only after `GAP_TICKS` (default 3) rising edges of `gapClk` with no bit pulse between them. `dataReady` goes high on that event and stays low while bits are still arriving.
- R3: Exactly 32 received bits leave `wordErr` low. Fewer or more bits set `wordErr`. The buffer holds the most recent 32 bits, with the last bit received at bit 32 (index 31) and earlier bits below it. Positions that were never filled read as 0.
- R4: With `parityEn` high, index 31 of the buffered word is replaced by a parity error bit. That bit is 1 when the 32 received bits hold an even number of ones, and 1 also sets `wordErr`.
- R5: With `parityEn` low, index 31 keeps the received bit and parity never sets `wordErr`.
- R6: Successive read strobes return bits [7:0], [15:8], [23:16] and [31:24]. The byte index moves on at the falling edge of each strobe and wraps back to [7:0] after the fourth read.
- R7: The first read strobe after a word is loaded clears `dataReady` at the next clock edge.
- R8: Loading a new word restarts the byte index at [7:0], whatever reads came before it.
- R9: While `rdStrobe` is low, `dataOut` is 0 and `dataOe` is low. While it is high, `dataOe` is high.
- R10: While `rstN` is low, `dataReady`, `wordErr`, the buffer, the byte index and any partly received word are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every other input is sampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| lineOne | input | 1 | Digital line whose pulses carry a one |
| lineZero | input | 1 | Digital line whose pulses carry a zero |
| gapClk | input | 1 | Slow clock used to time the inter-word gap |
| parityEn | input | 1 | High enables odd parity checking |
| rdStrobe | input | 1 | Host read strobe, active high, one byte per pulse |
| dataOut | output | 8 | Selected byte while strobed, else 0 |
| dataOe | output | 1 | High while the byte bus is driven |
| dataReady | output | 1 | A new word waits in the buffer |
| wordErr | output | 1 | Bit-count or parity error for the buffered word |

## Verification
The bench sends words of several shapes, and each one separates a different fault:
- An asymmetric pattern with parity off shows that bits land in the right positions and bytes come out in the right order.
- Words with odd and with even numbers of ones, including one whose top bit starts at 1, show whether bit 32 is replaced or passed through and whether parity can raise the error.
- Words of 31 and 33 bits show how the length check and the register alignment behave.
- Stray reads between words show that a load restarts the byte index.
- A fifth read shows that the index wraps.
- A reset in the middle of a word shows that a partly received word is thrown away.

// File: rtl/arx_pkg.sv
package arx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // shift a new bit in
    logic shiftBit;  // value of that bit
    logic load;      // close word: copy to buffer, clear input register
    logic lenBad;    // bit count of the closing word is wrong
  } arxStrobe_t;
endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_TICKS = 3,
  parameter int BYTES     = WORD_BITS / 8,
  localparam int CNT_W    = $clog2(WORD_BITS + 2),
  localparam int GAP_W    = $clog2(GAP_TICKS + 1),
  localparam int SEL_W    = (BYTES > 1) ? $clog2(BYTES) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineOne,
  input  logic             lineZero,
  input  logic             gapClk,
  input  logic             rdStrobe,
  output arxStrobe_t       strb,
  output logic [SEL_W-1:0] byteSel,
  output logic             dataReady
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_BITS + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(GAP_TICKS);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(BYTES - 1);

  logic orPrev, gapPrev, rdPrev;
  logic bitEvt, gapRise, rdRise, rdFall, endWord;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;

  assign bitEvt  = (lineOne | lineZero) & ~orPrev;
  assign gapRise = gapClk & ~gapPrev;
  assign rdRise  = rdStrobe & ~rdPrev;
  assign rdFall  = ~rdStrobe & rdPrev;
  assign endWord = gapRise & ~bitEvt & (gapCnt == GAP_LAST) & (bitCnt != '0);

  always_comb begin
    strb.shiftEn  = bitEvt;
    strb.shiftBit = lineOne;
    strb.load     = endWord;
    strb.lenBad   = (bitCnt != CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      orPrev  <= 1'b0;
      gapPrev <= 1'b0;
      rdPrev  <= 1'b0;
    end else begin
      orPrev  <= lineOne | lineZero;
      gapPrev <= gapClk;
      rdPrev  <= rdStrobe;
    end
  end

  // bit counter, saturating one past a full word
  always_ff @(posedge clk) begin
    if (!rstN)                       bitCnt <= '0;
    else if (endWord)                bitCnt <= '0;
    else if (bitEvt && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  // gap counter: gap-clock edges since the last bit pulse
  always_ff @(posedge clk) begin
    if (!rstN)                       gapCnt <= '0;
    else if (bitEvt)                 gapCnt <= '0;
    else if (gapRise && gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        byteSel <= '0;
    else if (endWord) byteSel <= '0;
    else if (rdFall)  byteSel <= (byteSel == SEL_LAST) ? '0 : byteSel + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        dataReady <= 1'b0;
    else if (endWord) dataReady <= 1'b1;
    else if (rdRise)  dataReady <= 1'b0;
  end

  // R2
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    endWord |=> dataReady);
  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRise && !endWord) |=> !dataReady);
  // R6
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdFall && !endWord && byteSel == SEL_LAST) |=> (byteSel == '0));
  // R8
  byte_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    endWord |=> (byteSel == '0));
endmodule

// File: rtl/arx_dpath.sv
module arx_dpath
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BYTES     = WORD_BITS / 8,
  localparam int SEL_W    = (BYTES > 1) ? $clog2(BYTES) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  arxStrobe_t       strb,
  input  logic [SEL_W-1:0] byteSel,
  input  logic             parityEn,
  input  logic             rdStrobe,
  output logic [7:0]       dataOut,
  output logic             dataOe,
  output logic             wordErr
);
  logic [WORD_BITS-1:0] shiftReg, bufWord, closed;
  logic                 parErr;
  logic [7:0]           byteArr [BYTES];

  // odd parity expected: an even count of ones is an error
  assign parErr = ~^shiftReg;

  always_comb begin
    closed = shiftReg;
    if (parityEn) closed[WORD_BITS-1] = parErr;
  end

  // newest bit enters at the top; the first bit ends at index 0
  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.load)    shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.shiftBit, shiftReg[WORD_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWord <= '0;
      wordErr <= 1'b0;
    end else if (strb.load) begin
      bufWord <= closed;
      wordErr <= strb.lenBad | (parityEn & parErr);
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_bytes
    assign byteArr[g] = bufWord[g*8 +: 8];
  end

  assign dataOut = rdStrobe ? byteArr[byteSel] : 8'h00;
  assign dataOe  = rdStrobe;

  // R3
  len_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.lenBad) |=> wordErr);
  // R5
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !parityEn) |=> (bufWord[WORD_BITS-1] == $past(shiftReg[WORD_BITS-1])));
  // R4
  parity_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && parityEn && parErr) |=> (wordErr && bufWord[WORD_BITS-1]));
endmodule

// File: rtl/arinc_word_rx.sv
module arinc_word_rx
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_TICKS = 3,
  localparam int BYTES    = WORD_BITS / 8,
  localparam int SEL_W    = (BYTES > 1) ? $clog2(BYTES) : 1
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineOne,
  input  logic       lineZero,
  input  logic       gapClk,
  input  logic       parityEn,
  input  logic       rdStrobe,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       dataReady,
  output logic       wordErr
);
  arxStrobe_t       strb;
  logic [SEL_W-1:0] byteSel;

  arx_ctrl #(.WORD_BITS(WORD_BITS), .GAP_TICKS(GAP_TICKS), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineOne(lineOne), .lineZero(lineZero),
    .gapClk(gapClk), .rdStrobe(rdStrobe), .strb(strb), .byteSel(byteSel),
    .dataReady(dataReady)
  );

  arx_dpath #(.WORD_BITS(WORD_BITS), .BYTES(BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteSel(byteSel),
    .parityEn(parityEn), .rdStrobe(rdStrobe), .dataOut(dataOut),
    .dataOe(dataOe), .wordErr(wordErr)
  );
endmodule

// File: tb/arinc_word_rx_bench.sv
module arinc_word_rx_bench;
  typedef struct {
    logic [31:0] word;
    logic        err;
    logic        wrap;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0, lineOne = 1'b0, lineZero = 1'b0, gapClk = 1'b0;
  logic parityEn = 1'b0, rdStrobe = 1'b0;
  logic [7:0] dataOut;
  logic dataOe, dataReady, wordErr;

  int nChk = 0, nFail = 0, nWords = 0;
  bit done = 1'b0;
  item_t expQ[$];
  logic bitsArr [0:39];

  arinc_word_rx u_arinc_word_rx (
    .clk(clk), .rstN(rstN), .lineOne(lineOne), .lineZero(lineZero),
    .gapClk(gapClk), .parityEn(parityEn), .rdStrobe(rdStrobe),
    .dataOut(dataOut), .dataOe(dataOe), .dataReady(dataReady), .wordErr(wordErr)
  );

  always #5 clk = ~clk;

  // free-running gap clock, 16 system clocks per period
  initial forever begin
    repeat (8) @(negedge clk);
    gapClk = ~gapClk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    if (b) lineOne = 1'b1; else lineZero = 1'b1;
    repeat (2) @(negedge clk);
    lineOne = 1'b0; lineZero = 1'b0;
    @(negedge clk);
  endtask

  // send n bits, push expected result: last 32 bits, newest at index 31
  task automatic sendWord(input int n, input bit par, input bit wrap);
    item_t it;
    logic [31:0] w = '0;
    int ones;
    parityEn = par;
    for (int k = 0; k < n; k++) begin
      int pos = 32 - n + k;
      if (pos >= 0) w[pos] = bitsArr[k];
    end
    ones = $countones(w);
    it.word = w;
    it.err  = (n != 32);
    if (par) begin
      it.word[31] = (ones % 2 == 0);
      if (ones % 2 == 0) it.err = 1'b1;
    end
    it.wrap = wrap;
    expQ.push_back(it);
    for (int k = 0; k < n; k++) sendBit(bitsArr[k]);
    repeat (4) @(negedge clk);
    check(dataReady == 1'b0, "R2 no ready before gap", {31'd0, dataReady}, 32'd0);
    repeat (110) @(negedge clk);
  endtask

  task automatic loadBits(input logic [39:0] v, input int n);
    for (int k = 0; k < n; k++) bitsArr[k] = v[k];
  endtask

  task automatic readByte(output logic [7:0] b, output logic oe);
    rdStrobe = 1'b1;
    @(negedge clk);
    b = dataOut; oe = dataOe;
    rdStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected words and reads bytes when ready rises
  initial begin
    item_t it;
    logic [7:0] b;
    logic oe;
    forever begin
      @(posedge dataReady);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected word", 32'd1, 32'd0);
        continue;
      end
      it = expQ.pop_front();
      nWords++;
      check(wordErr == it.err, "R3/R4/R5 error flag", {31'd0, wordErr}, {31'd0, it.err});
      for (int i = 0; i < 4; i++) begin
        rdStrobe = 1'b1;
        @(negedge clk);
        b = dataOut; oe = dataOe;
        if (i == 0) check(dataReady == 1'b0, "R7 first read clears ready", {31'd0, dataReady}, 32'd0);
        rdStrobe = 1'b0;
        check(oe == 1'b1, "R9 oe while strobed", {31'd0, oe}, 32'd1);
        check(b == it.word[i*8 +: 8], "R6 byte order / R1 R3 R4 R5 content", {24'd0, b}, {24'd0, it.word[i*8 +: 8]});
        repeat (2) @(negedge clk);
      end
      if (it.wrap) begin
        readByte(b, oe);
        check(b == it.word[7:0], "R6 wrap to first byte", {24'd0, b}, {24'd0, it.word[7:0]});
      end
    end
  end

  initial begin
    logic [7:0] b;
    logic oe;
    repeat (3) @(negedge clk);
    check(dataReady == 1'b0, "R10 ready after reset", {31'd0, dataReady}, 32'd0);
    check(wordErr == 1'b0, "R10 err after reset", {31'd0, wordErr}, 32'd0);
    check(dataOe == 1'b0 && dataOut == 8'h00, "R9 idle bus", {23'd0, dataOe, dataOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readByte(b, oe);
    check(b == 8'h00, "R10 buffer cleared", {24'd0, b}, 32'd0);

    // R1 R6 asymmetric pattern, parity off, with wrap read
    loadBits(40'h00_1234_5678, 32); sendWord(32, 1'b0, 1'b1);
    check(dataOe == 1'b0 && dataOut == 8'h00, "R9 idle bus after reads", {23'd0, dataOe, dataOut}, 32'd0);
    // R4 odd ones, top bit originally 1 -> replaced by 0
    loadBits(40'h00_8000_0003, 32); sendWord(32, 1'b1, 1'b0);
    // R4 even ones -> parity error
    loadBits(40'h00_FFFF_0000, 32); sendWord(32, 1'b1, 1'b0);
    // R5 even ones, parity off: top bit kept, no error
    loadBits(40'h00_A5A5_A5A5, 32); sendWord(32, 1'b0, 1'b0);
    // R3 short and long words
    loadBits(40'h00_7FFF_FFFF, 31); sendWord(31, 1'b0, 1'b0);
    loadBits(40'h01_C3C3_3C3C, 33); sendWord(33, 1'b0, 1'b0);
    // R8 stray reads then a new word starts at byte 0
    readByte(b, oe); readByte(b, oe);
    loadBits(40'h00_DEAD_BEEF, 32); sendWord(32, 1'b0, 1'b0);
    // R10 reset in mid-word discards partial bits
    loadBits(40'h00_0000_03FF, 10);
    for (int k = 0; k < 10; k++) sendBit(bitsArr[k]);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(dataReady == 1'b0 && wordErr == 1'b0, "R10 flags in reset", {30'd0, dataReady, wordErr}, 32'd0);
    rstN = 1'b1;
    loadBits(40'h00_0F0F_1357, 32); sendWord(32, 1'b0, 1'b0);

    check(expQ.size() == 0, "R2 all words delivered", expQ.size(), 32'd0);
    check(nWords == 8, "R2 word count", nWords, 32'd8);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", cyc, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule